// File: doc/BRIEF.md
# Dual Countdown Timer with Shared Interrupt

This peripheral holds two independent 32-bit down-counters behind a small word-wide register bus (address, write strobe, write data, combinational read data). Each counter has a reload word and a control word. The control word carries a 2-bit operation code and a 3-bit tick-source selector. The operation code copies the reload word into the counter, freezes the counter, or lets it run. A running counter steps down once for each cycle in which its selected tick-enable input is high. When it expires it reloads itself and raises a pending bit, so it fires periodically.

The two pending bits feed one interrupt unit. That unit holds a mask word and a write-one-to-clear acknowledge port, and drives a single active-high interrupt line. Software programs the reload word first. It then issues a load, then a run, and services the interrupt by acknowledging the pending bit.

Top module: `dual_countdown_timer`

## Requirements
- R1: Register offsets are as follows. Counter 0 uses 0x00 reload, 0x04 count and 0x08 control. Counter 1 uses the same layout at +0x10. Mask is at 0x48, acknowledge at 0x4C, raw pending at 0x50 and masked pending at 0x54. Count, mask, raw and masked read back, with unused upper bits reading 0. Reload, control, acknowledge and every unmapped offset read 0.
- R2: A control write with op bits [1:0] = 0 (load) copies the current reload word into the counter. The counter does not advance in load mode.
- R3: Op = 1 (hold) freezes the counter. Ticks have no effect on it.
- R4: In op = 2 (run), the counter drops by one on each cycle where the tick input picked by control bits [4:2] is high. Selector 4, 5, 6 or 7 picks tick_src[0], [1], [2] or [3]. Selector 0 to 3 picks no tick, so the counter stays put.
- R5: A running counter that sees a tick while at 0 reloads from its reload word and sets its raw pending bit. Counter 0 sets bit 0 and counter 1 sets bit 1. With reload N, the period is N+1 ticks.
- R6: A control write with op = 3 is ignored entirely. Mode, selector and counter all keep their previous state.
- R7: Writing the acknowledge port clears each raw bit that is 1 in the written value and leaves the other raw bits alone.
- R8: When an expiry and an acknowledge of the same bit fall in the same cycle, the bit ends up set.
- R9: Masked pending equals raw AND mask. irq_o is high exactly when a masked bit is set.
- R10: Reset stops both counters (hold mode, count 0, reload 0) and clears raw and mask, so irq_o is low.
- R11: Writes to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the word accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_src | input | 4 | Prescaled tick-enable inputs, selectable per counter |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
The bench targets the expiry step. A counter that fired on reaching 0 instead of ticking at 0 would show a period one tick short, and one that forgot to reload would stay at 0. An illegal op code is written while the counter is in hold and then ticked. A design that decoded op 3 as run, or stored it, would let the count move. Tick lines belonging to the other counter and the non-selecting selector codes are pulsed to catch a wrong source mapping. An acknowledge that lands in the same cycle as an expiry must leave the bit set; a design that gives the clear priority would drop the interrupt and lose an event.

// File: rtl/dct_pkg.sv
package dct_pkg;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_HOLD = 2'd1,
        OP_RUN  = 2'd2,
        OP_BAD  = 2'd3
    } dct_op_e;

    localparam int NUM_TMR    = 2;
    localparam int TMR_STRIDE = 16;

    // byte offsets inside one counter's window
    localparam int OFS_RELOAD = 0;
    localparam int OFS_COUNT  = 4;
    localparam int OFS_CTRL   = 8;

    // interrupt unit offsets
    localparam int OFS_MASK   = 'h48;
    localparam int OFS_ACK    = 'h4C;
    localparam int OFS_RAW    = 'h50;
    localparam int OFS_MSKD   = 'h54;

endpackage

// File: rtl/dct_channel.sv
module dct_channel
    import dct_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_TICKS = 4,
    parameter int SRC_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_reload,
    input  logic                 wr_ctrl,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [NUM_TICKS-1:0] tick_src,
    output logic [DATA_W-1:0]    count_o,
    output logic                 expire_o
);

    localparam int FIRST_SRC = 1 << (SRC_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] reload;
        logic [DATA_W-1:0] count;
        dct_op_e           op;
        logic [SRC_W-1:0]  src;
    } chan_t;

    chan_t   st_d, st_q;
    logic    tick;
    dct_op_e op_in;

    assign op_in = dct_op_e'(wdata[1:0]);

    // selector FIRST_SRC+i picks tick_src[i]; lower codes pick nothing
    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < NUM_TICKS; i++) begin
            if (st_q.src == SRC_W'(FIRST_SRC + i)) tick = tick_src[i];
        end
    end

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (wr_reload) st_d.reload = wdata;
        if (wr_ctrl && op_in != OP_BAD) begin
            st_d.op  = op_in;
            st_d.src = wdata[2 +: SRC_W];
            if (op_in == OP_LOAD) st_d.count = st_q.reload;
        end else if (st_q.op == OP_RUN && tick) begin
            if (st_q.count == '0) begin
                expire_o   = 1'b1;
                st_d.count = st_q.reload;
            end else begin
                st_d.count = st_q.count - DATA_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.reload <= '0;
            st_q.count  <= '0;
            st_q.op     <= OP_HOLD;
            st_q.src    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;

    // R3: a counter not in run mode keeps its value unless a load arrives
    a_r3_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.op != OP_RUN && !wr_ctrl) |=> $stable(count_o));

    // R4: one tick below zero-crossing takes exactly one off the count
    a_r4_run_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.op == OP_RUN && tick && count_o != '0 && !wr_ctrl)
        |=> (count_o == $past(count_o) - DATA_W'(1)));

    // R5: a tick at zero reloads from the reload word
    a_r5_reload_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.op == OP_RUN && tick && count_o == '0 && !wr_ctrl)
        |=> (count_o == $past(st_q.reload)));

    // R6: an illegal op code leaves the mode untouched
    a_r6_bad_op_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[1:0] == 2'd3) |=> (st_q.op == $past(st_q.op)));

endmodule

// File: rtl/dct_irq_unit.sv
module dct_irq_unit #(
    parameter int NUM_TMR = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_TMR-1:0] expire,
    input  logic               wr_mask,
    input  logic               wr_ack,
    input  logic [NUM_TMR-1:0] wdata,
    output logic [NUM_TMR-1:0] raw_o,
    output logic [NUM_TMR-1:0] mask_o,
    output logic               irq_o
);

    typedef struct packed {
        logic [NUM_TMR-1:0] raw;
        logic [NUM_TMR-1:0] mask;
    } irq_t;

    irq_t               st_d, st_q;
    logic [NUM_TMR-1:0] clr;

    always_comb begin
        st_d     = st_q;
        clr      = wr_ack ? wdata : '0;
        // expiry is applied after the clear so it wins on a collision
        st_d.raw = (st_q.raw & ~clr) | expire;
        if (wr_mask) st_d.mask = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_o  = st_q.raw;
    assign mask_o = st_q.mask;
    assign irq_o  = |(st_q.raw & st_q.mask);

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
        // R8: an expiry always leaves its pending bit set
        a_r8_expiry_wins: assert property (@(posedge clk) disable iff (!rst_n)
            expire[i] |=> raw_o[i]);
        // R7: an acknowledged bit with no concurrent expiry is cleared
        a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_ack && wdata[i] && !expire[i]) |=> !raw_o[i]);
    end

    // R9: the request line is never high without a pending bit behind it
    a_r9_irq_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (raw_o != '0 && mask_o != '0));

endmodule

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer
    import dct_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int NUM_TICKS = 4,
    parameter int SRC_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_TICKS-1:0] tick_src,
    output logic                 irq_o
);

    logic [NUM_TMR-1:0] expire;
    logic [NUM_TMR-1:0] raw, mask;
    logic [DATA_W-1:0]  count [NUM_TMR];
    logic               wr_mask, wr_ack;

    assign wr_mask = bus_we && bus_addr == ADDR_W'(OFS_MASK);
    assign wr_ack  = bus_we && bus_addr == ADDR_W'(OFS_ACK);

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        logic wr_reload, wr_ctrl;
        assign wr_reload = bus_we && bus_addr == ADDR_W'(i * TMR_STRIDE + OFS_RELOAD);
        assign wr_ctrl   = bus_we && bus_addr == ADDR_W'(i * TMR_STRIDE + OFS_CTRL);

        dct_channel #(
            .DATA_W    (DATA_W),
            .NUM_TICKS (NUM_TICKS),
            .SRC_W     (SRC_W)
        ) chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_reload (wr_reload),
            .wr_ctrl   (wr_ctrl),
            .wdata     (bus_wdata),
            .tick_src  (tick_src),
            .count_o   (count[i]),
            .expire_o  (expire[i])
        );
    end

    dct_irq_unit #(
        .NUM_TMR (NUM_TMR)
    ) irq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire),
        .wr_mask (wr_mask),
        .wr_ack  (wr_ack),
        .wdata   (bus_wdata[NUM_TMR-1:0]),
        .raw_o   (raw),
        .mask_o  (mask),
        .irq_o   (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (bus_addr == ADDR_W'(i * TMR_STRIDE + OFS_COUNT)) bus_rdata = count[i];
        end
        if (bus_addr == ADDR_W'(OFS_MASK)) bus_rdata = DATA_W'(mask);
        if (bus_addr == ADDR_W'(OFS_RAW))  bus_rdata = DATA_W'(raw);
        if (bus_addr == ADDR_W'(OFS_MSKD)) bus_rdata = DATA_W'(raw & mask);
    end

    // R1: the acknowledge port never reads back a value
    a_r1_ack_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_ACK)) |-> (bus_rdata == '0));

endmodule

// File: tb/dual_countdown_timer_tb_top.sv
module dual_countdown_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  tick_src = '0;
    logic        irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dual_countdown_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_src  (tick_src),
        .irq_o     (irq_o)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        we;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [3:0]  tick;
        logic [7:0]  raddr;
        logic [31:0] exp;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{4'd1,  1'b1, 8'h00, 32'd3,        4'h0, 8'h04, 32'd0, 1'b0}, // R1 reload not yet in count
        '{4'd2,  1'b1, 8'h08, 32'h10,       4'h0, 8'h04, 32'd3, 1'b0}, // R2 load
        '{4'd4,  1'b1, 8'h08, 32'h12,       4'h0, 8'h04, 32'd3, 1'b0}, // R4 run, src 4
        '{4'd4,  1'b0, 8'h00, 32'd0,        4'h1, 8'h04, 32'd2, 1'b0}, // R4 step
        '{4'd4,  1'b0, 8'h00, 32'd0,        4'h2, 8'h04, 32'd2, 1'b0}, // R4 other line
        '{4'd4,  1'b0, 8'h00, 32'd0,        4'h1, 8'h04, 32'd1, 1'b0}, // R4
        '{4'd4,  1'b0, 8'h00, 32'd0,        4'h1, 8'h04, 32'd0, 1'b0}, // R4 reaches zero, no expiry yet
        '{4'd5,  1'b0, 8'h00, 32'd0,        4'h1, 8'h50, 32'd1, 1'b0}, // R5 expiry bit 0
        '{4'd9,  1'b1, 8'h48, 32'd1,        4'h0, 8'h54, 32'd1, 1'b1}, // R9 masked, irq
        '{4'd7,  1'b1, 8'h4C, 32'd1,        4'h0, 8'h50, 32'd0, 1'b0}, // R7 ack clears
        '{4'd1,  1'b0, 8'h00, 32'd0,        4'h0, 8'h4C, 32'd0, 1'b0}, // R1 ack reads zero
        '{4'd5,  1'b1, 8'h08, 32'h11,       4'h0, 8'h04, 32'd3, 1'b0}, // R5 count reloaded to 3
        '{4'd3,  1'b0, 8'h00, 32'd0,        4'h1, 8'h04, 32'd3, 1'b0}, // R3 hold
        '{4'd6,  1'b1, 8'h08, 32'h13,       4'h0, 8'h04, 32'd3, 1'b0}, // R6 illegal op
        '{4'd6,  1'b0, 8'h00, 32'd0,        4'h1, 8'h04, 32'd3, 1'b0}, // R6 still held
        '{4'd1,  1'b1, 8'h10, 32'd1,        4'h0, 8'h14, 32'd0, 1'b0}, // R1 timer 1 window
        '{4'd2,  1'b1, 8'h18, 32'h14,       4'h0, 8'h14, 32'd1, 1'b0}, // R2 load src 5
        '{4'd4,  1'b1, 8'h18, 32'h16,       4'h0, 8'h14, 32'd1, 1'b0}, // R4 run
        '{4'd4,  1'b0, 8'h00, 32'd0,        4'h2, 8'h14, 32'd0, 1'b0}, // R4
        '{4'd5,  1'b0, 8'h00, 32'd0,        4'h2, 8'h50, 32'd2, 1'b0}, // R5 expiry bit 1, masked off
        '{4'd9,  1'b1, 8'h48, 32'd3,        4'h0, 8'h54, 32'd2, 1'b1}, // R9
        '{4'd7,  1'b1, 8'h4C, 32'd1,        4'h0, 8'h50, 32'd2, 1'b1}, // R7 other bit kept
        '{4'd7,  1'b1, 8'h4C, 32'd2,        4'h0, 8'h50, 32'd0, 1'b0}, // R7
        '{4'd4,  1'b1, 8'h18, 32'h06,       4'h0, 8'h14, 32'd1, 1'b0}, // R4 selector 1
        '{4'd4,  1'b0, 8'h00, 32'd0,        4'hF, 8'h14, 32'd1, 1'b0}, // R4 no tick source
        '{4'd4,  1'b1, 8'h18, 32'h1E,       4'h0, 8'h14, 32'd1, 1'b0}, // R4 selector 7
        '{4'd4,  1'b0, 8'h00, 32'd0,        4'h4, 8'h14, 32'd1, 1'b0}, // R4 line 2 ignored
        '{4'd4,  1'b0, 8'h00, 32'd0,        4'h8, 8'h14, 32'd0, 1'b0}, // R4 line 3
        '{4'd1,  1'b0, 8'h00, 32'd0,        4'h0, 8'h00, 32'd0, 1'b0}, // R1 reload reads zero
        '{4'd1,  1'b0, 8'h00, 32'd0,        4'h0, 8'h08, 32'd0, 1'b0}, // R1 control reads zero
        '{4'd11, 1'b1, 8'h20, 32'hFFFFFFFF, 4'h0, 8'h48, 32'd3, 1'b0}, // R11 unmapped write
        '{4'd11, 1'b0, 8'h00, 32'd0,        4'h0, 8'h50, 32'd0, 1'b0}  // R11 raw untouched
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic we, input logic [7:0] addr, input logic [31:0] wd,
                         input logic [3:0] tk, input logic [7:0] raddr);
        @(negedge clk);
        bus_we = we; bus_addr = addr; bus_wdata = wd; tick_src = tk;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; tick_src = '0; bus_addr = raddr;
        #1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R10 reset state
        bus_addr = 8'h04; #1; check("R10 count0", bus_rdata, 0);
        bus_addr = 8'h50; #1; check("R10 raw", bus_rdata, 0);
        bus_addr = 8'h48; #1; check("R10 mask", bus_rdata, 0);
        check("R10 irq", {31'd0, irq_o}, 0);

        for (int v = 0; v < NV; v++) begin
            apply(VECS[v].we, VECS[v].addr, VECS[v].wdata, VECS[v].tick, VECS[v].raddr);
            n_chk++;
            if (bus_rdata !== VECS[v].exp || irq_o !== VECS[v].exp_irq) begin
                n_fail++;
                $display("FAIL vector %0d R%0d: got 0x%0h/irq %0b expected 0x%0h/irq %0b",
                         v, VECS[v].req, bus_rdata, irq_o, VECS[v].exp, VECS[v].exp_irq);
            end
        end

        // R8: expiry of counter 0 and acknowledge of bit 0 in one cycle
        apply(1'b1, 8'h00, 32'd0,  4'h0, 8'h04);
        apply(1'b1, 8'h08, 32'h10, 4'h0, 8'h04);
        check("R2 load zero", bus_rdata, 0);
        apply(1'b1, 8'h08, 32'h12, 4'h0, 8'h04);
        apply(1'b1, 8'h4C, 32'd1,  4'h1, 8'h50);
        check("R8 expiry wins", bus_rdata, 1);
        check("R8 irq", {31'd0, irq_o}, 1);
        bus_addr = 8'h04; #1;
        check("R5 reload zero", bus_rdata, 0);

        // R10 reset in the middle of activity
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); @(negedge clk); rst_n = 1'b1;
        bus_addr = 8'h50; #1; check("R10 raw after reset", bus_rdata, 0);
        bus_addr = 8'h48; #1; check("R10 mask after reset", bus_rdata, 0);
        check("R10 irq after reset", {31'd0, irq_o}, 0);
        apply(1'b0, 8'h00, 32'd0, 4'hF, 8'h14);
        check("R10 counter stopped", bus_rdata, 0);

        done = 1'b1;
        finish_run();
    end

endmodule